// File: doc/BRIEF.md
# Write-Back Cache Controller with Single-Entry Eviction Buffer

This block is the control and storage core of a direct-mapped, write-back data cache. A processor-side request port takes single-word reads and writes. Each accepted request spends one cycle in a tag lookup. Hits are answered at the end of that lookup. Misses fetch a whole block from memory through a block-read port, and dirty blocks return to memory through a separate block-write port. Only one of the two memory ports may request in any given cycle.

One eviction buffer decouples the two directions of traffic. When a miss displaces a modified block, that block moves into the buffer, the read for the new block goes out at once, and the processor gets its answer as soon as the fill arrives. The buffer drains later, while the cache is idle or serving hits. A second dirty eviction cannot proceed while the buffer is still occupied, so that miss first waits for the buffer to drain. A read that asks for the very block sitting in the buffer takes it back without any memory access.

Request handshake: a request is taken on a cycle where `cpu_req_valid` and `cpu_req_ready` are both high. Ready is high only while the controller is idle, and the requester holds its signals until they are taken. Responses have no back-pressure: `cpu_rsp_valid` pulses for one cycle. Memory reads: `mem_rd_valid` and `mem_rd_addr` stay steady until a cycle with `mem_rd_ready` high, and that cycle also carries `mem_rd_data`. Memory writes: a block is written on a cycle with `mem_wr_valid` and `mem_wr_ready` both high. A pending write may be withdrawn or replaced when the processor reclaims the buffered block.

Top module: `wb_cache_ctrl`

## Requirements
- R1: After reset `cpu_req_ready` is 1, neither memory port requests, and every line is invalid, so the first access to any address misses.
- R2: A request is accepted only while `cpu_req_ready` is 1. Ready then stays 0 until the response cycle and returns to 1 in the cycle after it. A response never appears while ready is 1.
- R3: A read hit answers one cycle after acceptance with the stored word and produces no memory traffic.
- R4: A write hit answers one cycle after acceptance, replaces one word, and marks the line modified. That word reaches memory only when the line is later evicted and drained.
- R5: A miss whose victim is invalid or clean raises a block read for address bits [ADDR_W-1:OFF_W] and holds it steady until `mem_rd_ready`. The response comes in that same ready cycle, and no block write occurs.
- R6: A miss with a modified victim and an empty buffer moves the victim into the buffer and issues the block read first. The buffered write is requested only after the response, with the victim's block address.
- R7: While the buffer waits for `mem_wr_ready`, hits are still answered one cycle after acceptance.
- R8: A miss that arrives while the buffer holds another block issues no read until that buffered block has been accepted by memory. After that, the read goes out.
- R9: A miss on the block held in the buffer is answered one cycle after acceptance from the buffer with no block read. The block returns to the cache as modified, and a clean victim displaced by it leaves the buffer empty.
- R10: A write miss fetches the block, merges the written word, answers in the fill cycle, and marks the line modified.
- R11: `mem_rd_valid` and `mem_wr_valid` are never high in the same cycle.
- R12: Word address fields are: word offset = bits [OFF_W-1:0], line index = the next IDX_W bits, tag = the remaining upper bits. In a block, word i sits at bits [i*WORD_W +: WORD_W]. The response carries the word the offset selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Controller can take a request |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | WORD_W | Write data |
| cpu_rsp_valid | output | 1 | One-cycle response strobe |
| cpu_rsp_rdata | output | WORD_W | Read word (write data echoed for writes) |
| mem_rd_valid | output | 1 | Block read request |
| mem_rd_addr | output | ADDR_W-OFF_W | Block address to read |
| mem_rd_ready | input | 1 | Read data present this cycle |
| mem_rd_data | input | LINE_WORDS*WORD_W | Block read data |
| mem_wr_valid | output | 1 | Block write request from the buffer |
| mem_wr_addr | output | ADDR_W-OFF_W | Block address to write |
| mem_wr_data | output | LINE_WORDS*WORD_W | Block write data |
| mem_wr_ready | input | 1 | Memory takes the write this cycle |

## Verification
The bound checker watches, every cycle, the handshake rules that can be seen at the ports. These are the exclusive use of the memory channel, a steady read request until it is served, the busy window between acceptance and response, and the response that comes with a fill. Whether data is correct, which requests hit or miss, the ordering of a buffered write against a later read, and buffer reclaim all depend on the history of addresses. Only the bench's scenarios show these, comparing responses and memory contents against its own reference model with a controllable memory that can hold off writes.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_DRAIN  = 2'd2,
    ST_FILL   = 2'd3
  } wbc_state_e;

endpackage

// File: rtl/wbc_tag_array.sv
module wbc_tag_array #(
  parameter int LINES = 8,
  parameter int TAG_W = 7,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_dirty
);

  logic [LINES-1:0] valid_vec;
  logic [LINES-1:0] dirty_vec;
  logic [TAG_W-1:0] tag_vec [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic             v_q;
    logic             d_q;
    logic [TAG_W-1:0] t_q;
    logic             sel;

    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
      end else if (sel) begin
        v_q <= 1'b1;
        d_q <= wr_dirty;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) t_q <= wr_tag;
    end

    assign valid_vec[g] = v_q;
    assign dirty_vec[g] = d_q;
    assign tag_vec[g]   = t_q;
  end

  assign rd_valid = valid_vec[rd_idx];
  assign rd_dirty = dirty_vec[rd_idx];
  assign rd_tag   = tag_vec[rd_idx];

endmodule

// File: rtl/wbc_data_array.sv
module wbc_data_array #(
  parameter int LINES  = 8,
  parameter int LINE_W = 128,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_line
);

  logic [LINE_W-1:0] store_q [LINES];

  always_ff @(posedge clk) begin
    if (wr_en) store_q[wr_idx] <= wr_line;
  end

  assign rd_line = store_q[rd_idx];

endmodule

// File: rtl/wbc_write_buffer.sv
module wbc_write_buffer #(
  parameter int BLK_W  = 10,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BLK_W-1:0]  load_blk,
  input  logic [LINE_W-1:0] load_line,
  input  logic              clear,
  input  logic              pop,
  output logic              valid,
  output logic [BLK_W-1:0]  blk,
  output logic [LINE_W-1:0] line
);

  logic              valid_q;
  logic [BLK_W-1:0]  blk_q;
  logic [LINE_W-1:0] line_q;

  // A load wins over a pop in the same cycle: the old entry has just left.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              valid_q <= 1'b0;
    else if (load)           valid_q <= 1'b1;
    else if (clear || pop)   valid_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      blk_q  <= load_blk;
      line_q <= load_line;
    end
  end

  assign valid = valid_q;
  assign blk   = blk_q;
  assign line  = line_q;

endmodule

// File: rtl/wb_cache_ctrl.sv
module wb_cache_ctrl
  import wbc_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int LINES      = 8,
  localparam int OFF_W  = $clog2(LINE_WORDS),
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int BLK_W  = ADDR_W - OFF_W,
  localparam int LINE_W = LINE_WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [WORD_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [WORD_W-1:0] cpu_rsp_rdata,
  output logic              mem_rd_valid,
  output logic [BLK_W-1:0]  mem_rd_addr,
  input  logic              mem_rd_ready,
  input  logic [LINE_W-1:0] mem_rd_data,
  output logic              mem_wr_valid,
  output logic [BLK_W-1:0]  mem_wr_addr,
  output logic [LINE_W-1:0] mem_wr_data,
  input  logic              mem_wr_ready
);

  wbc_state_e state_q, state_d;

  // latched request
  logic              r_we;
  logic [ADDR_W-1:0] r_addr;
  logic [WORD_W-1:0] r_wdata;

  logic [OFF_W-1:0]  r_off;
  logic [IDX_W-1:0]  r_idx;
  logic [TAG_W-1:0]  r_tag;
  logic [BLK_W-1:0]  r_blk;

  // array and buffer views
  logic              t_valid, t_dirty;
  logic [TAG_W-1:0]  t_tag;
  logic [LINE_W-1:0] line_q;
  logic              wb_valid;
  logic [BLK_W-1:0]  wb_blk;
  logic [LINE_W-1:0] wb_line;

  // decisions
  logic hit, vic_dirty, wb_match;
  logic in_lookup;
  logic ev_hit, ev_reclaim, ev_miss, ev_drained, ev_fill_done, ev_go_fill;
  logic upd_en, upd_dirty;
  logic wb_load, wb_pop;
  logic [BLK_W-1:0]  vic_blk;
  logic [LINE_W-1:0] base_line, merged_line;
  logic [WORD_W-1:0] merged_word [LINE_WORDS];

  // ---------------------------------------------------------------
  // request capture
  // ---------------------------------------------------------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_we    <= 1'b0;
      r_addr  <= '0;
      r_wdata <= '0;
    end else if (cpu_req_valid && cpu_req_ready) begin
      r_we    <= cpu_req_we;
      r_addr  <= cpu_req_addr;
      r_wdata <= cpu_req_wdata;
    end
  end

  assign r_off = r_addr[OFF_W-1:0];
  assign r_idx = r_addr[OFF_W +: IDX_W];
  assign r_tag = r_addr[ADDR_W-1 -: TAG_W];
  assign r_blk = r_addr[ADDR_W-1:OFF_W];

  // ---------------------------------------------------------------
  // storage
  // ---------------------------------------------------------------
  wbc_tag_array #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (r_idx),
    .rd_valid (t_valid),
    .rd_dirty (t_dirty),
    .rd_tag   (t_tag),
    .wr_en    (upd_en),
    .wr_idx   (r_idx),
    .wr_tag   (r_tag),
    .wr_dirty (upd_dirty)
  );

  wbc_data_array #(.LINES(LINES), .LINE_W(LINE_W)) u_data (
    .clk     (clk),
    .rd_idx  (r_idx),
    .rd_line (line_q),
    .wr_en   (upd_en),
    .wr_idx  (r_idx),
    .wr_line (merged_line)
  );

  wbc_write_buffer #(.BLK_W(BLK_W), .LINE_W(LINE_W)) u_wbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (wb_load),
    .load_blk  (vic_blk),
    .load_line (line_q),
    .clear     (ev_reclaim),
    .pop       (wb_pop),
    .valid     (wb_valid),
    .blk       (wb_blk),
    .line      (wb_line)
  );

  // ---------------------------------------------------------------
  // lookup and event decode
  // ---------------------------------------------------------------
  assign hit       = t_valid && (t_tag == r_tag);
  assign vic_dirty = t_valid && t_dirty;
  assign vic_blk   = {t_tag, r_idx};
  assign wb_match  = wb_valid && (wb_blk == r_blk);
  assign in_lookup = (state_q == ST_LOOKUP);

  assign ev_hit       = in_lookup && hit;
  assign ev_reclaim   = in_lookup && !hit && wb_match;
  assign ev_miss      = in_lookup && !hit && !wb_match;
  // the drain can also finish while still in lookup, so an empty buffer ends the wait
  assign ev_drained   = (state_q == ST_DRAIN) && (!wb_valid || mem_wr_ready);
  assign ev_fill_done = (state_q == ST_FILL) && mem_rd_ready;
  assign ev_go_fill   = (ev_miss && !wb_valid) || ev_drained;

  assign wb_load = (ev_go_fill || ev_reclaim) && vic_dirty;
  assign wb_pop  = mem_wr_valid && mem_wr_ready;

  // ---------------------------------------------------------------
  // line update: pick the source, then merge the written word
  // ---------------------------------------------------------------
  always_comb begin
    if (state_q == ST_FILL) base_line = mem_rd_data;
    else if (hit)           base_line = line_q;
    else                    base_line = wb_line;
  end

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
    assign merged_word[w] = (r_we && (r_off == OFF_W'(w))) ? r_wdata
                                                            : base_line[w*WORD_W +: WORD_W];
    assign merged_line[w*WORD_W +: WORD_W] = merged_word[w];
  end

  assign upd_en    = (ev_hit && r_we) || ev_reclaim || ev_fill_done;
  assign upd_dirty = ev_fill_done ? r_we : 1'b1;

  // ---------------------------------------------------------------
  // state sequencing
  // ---------------------------------------------------------------
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (cpu_req_valid) state_d = ST_LOOKUP;
      ST_LOOKUP: begin
        if (ev_hit || ev_reclaim) state_d = ST_IDLE;
        else if (wb_valid)        state_d = ST_DRAIN;
        else                      state_d = ST_FILL;
      end
      ST_DRAIN:  if (ev_drained)   state_d = ST_FILL;
      ST_FILL:   if (mem_rd_ready) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // ---------------------------------------------------------------
  // outputs
  // ---------------------------------------------------------------
  assign cpu_req_ready = (state_q == ST_IDLE);
  assign cpu_rsp_valid = ev_hit || ev_reclaim || ev_fill_done;
  assign cpu_rsp_rdata = merged_word[r_off];

  assign mem_rd_valid  = (state_q == ST_FILL);
  assign mem_rd_addr   = r_blk;
  assign mem_wr_valid  = wb_valid && (state_q != ST_FILL);
  assign mem_wr_addr   = wb_blk;
  assign mem_wr_data   = wb_line;

endmodule

// File: rtl/wbc_checker.sv
module wbc_checker #(
  parameter int BLK_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_req_valid,
  input logic             cpu_req_ready,
  input logic             cpu_rsp_valid,
  input logic             mem_rd_valid,
  input logic [BLK_W-1:0] mem_rd_addr,
  input logic             mem_rd_ready,
  input logic             mem_wr_valid,
  input logic             mem_wr_ready
);

  assert_channel_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_valid && mem_wr_valid));

  assert_read_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  assert_fill_answers_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && mem_rd_ready |-> cpu_rsp_valid);

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid && cpu_req_ready |=> !cpu_req_ready);

  assert_ready_after_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |=> cpu_req_ready);

  assert_no_rsp_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |-> !cpu_req_ready);

  assert_no_write_during_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !(mem_wr_valid && mem_wr_ready));

endmodule

bind wb_cache_ctrl wbc_checker #(.BLK_W(BLK_W)) u_wbc_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_req_valid (cpu_req_valid),
  .cpu_req_ready (cpu_req_ready),
  .cpu_rsp_valid (cpu_rsp_valid),
  .mem_rd_valid  (mem_rd_valid),
  .mem_rd_addr   (mem_rd_addr),
  .mem_rd_ready  (mem_rd_ready),
  .mem_wr_valid  (mem_wr_valid),
  .mem_wr_ready  (mem_wr_ready)
);

// File: tb/wb_cache_ctrl_bench.sv
module wb_cache_ctrl_bench;

  localparam int ADDR_W     = 12;
  localparam int WORD_W     = 32;
  localparam int LINE_WORDS = 4;
  localparam int LINES      = 8;
  localparam int OFF_W      = 2;
  localparam int BLK_W      = 10;
  localparam int LINE_W     = 128;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              cpu_req_valid = 1'b0;
  logic              cpu_req_ready;
  logic              cpu_req_we = 1'b0;
  logic [ADDR_W-1:0] cpu_req_addr = '0;
  logic [WORD_W-1:0] cpu_req_wdata = '0;
  logic              cpu_rsp_valid;
  logic [WORD_W-1:0] cpu_rsp_rdata;
  logic              mem_rd_valid;
  logic [BLK_W-1:0]  mem_rd_addr;
  logic              mem_rd_ready = 1'b0;
  logic [LINE_W-1:0] mem_rd_data = '0;
  logic              mem_wr_valid;
  logic [BLK_W-1:0]  mem_wr_addr;
  logic [LINE_W-1:0] mem_wr_data;
  logic              mem_wr_ready = 1'b0;

  wb_cache_ctrl #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS), .LINES(LINES)
  ) u_wb_cache_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ready(mem_rd_ready), .mem_rd_data(mem_rd_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_ready(mem_wr_ready)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  always @(posedge clk) cyc++;

  task automatic check(input string what, input logic [LINE_W-1:0] act,
                       input logic [LINE_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // ---------------- reference contents ----------------
  function automatic logic [WORD_W-1:0] init_word(input logic [ADDR_W-1:0] a);
    return {a, 8'h5A, a};
  endfunction

  logic [WORD_W-1:0] gold   [int];
  logic [LINE_W-1:0] mem_blk [int];

  function automatic logic [WORD_W-1:0] gold_rd(input logic [ADDR_W-1:0] a);
    if (gold.exists(int'(a))) return gold[int'(a)];
    return init_word(a);
  endfunction

  function automatic logic [LINE_W-1:0] blk_read(input int b);
    logic [LINE_W-1:0] r;
    if (mem_blk.exists(b)) return mem_blk[b];
    for (int i = 0; i < LINE_WORDS; i++)
      r[i*WORD_W +: WORD_W] = init_word(ADDR_W'((b << OFF_W) + i));
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] mk(input logic [6:0] t, input logic [2:0] i,
                                           input logic [1:0] o);
    return {t, i, o};
  endfunction

  // ---------------- memory model ----------------
  int rd_lat = 0, rd_cnt = 0;
  bit wr_block = 1'b0;
  int rd_fires = 0, wr_fires = 0, rd_fire_cyc = 0, wr_fire_cyc = 0;

  always @(negedge clk) begin
    if (mem_rd_valid) begin
      if (rd_cnt >= rd_lat) begin
        mem_rd_ready = 1'b1;
        mem_rd_data  = blk_read(int'(mem_rd_addr));
        rd_cnt = 0;
        rd_fires++;
        rd_fire_cyc = cyc;
      end else begin
        mem_rd_ready = 1'b0;
        rd_cnt++;
      end
    end else begin
      mem_rd_ready = 1'b0;
      rd_cnt = 0;
    end
    if (mem_wr_valid && !wr_block) begin
      mem_wr_ready = 1'b1;
      mem_blk[int'(mem_wr_addr)] = mem_wr_data;
      wr_fires++;
      wr_fire_cyc = cyc;
    end else begin
      mem_wr_ready = 1'b0;
    end
  end

  // ---------------- scoreboard monitor ----------------
  logic [WORD_W-1:0] exp_q [$];
  int rsp_cnt  = 0;
  int both_cnt = 0;

  always begin
    @(negedge clk);
    #2;
    if (rst_n && mem_rd_valid && mem_wr_valid) both_cnt++;
    if (rst_n && cpu_rsp_valid) begin
      rsp_cnt++;
      if (exp_q.size() == 0) begin
        n_checks++;
        n_fail++;
        $display("FAIL R2 unexpected response actual=%0h expected=none", cpu_rsp_rdata);
      end else begin
        logic [WORD_W-1:0] e;
        e = exp_q.pop_front();
        check("R12 response word", LINE_W'(cpu_rsp_rdata), LINE_W'(e));
      end
    end
  end

  // ---------------- driver ----------------
  task automatic do_req(input bit we, input logic [ADDR_W-1:0] a,
                        input logic [WORD_W-1:0] d, output int lat);
    int seen;
    @(negedge clk);
    cpu_req_valid = 1'b1;
    cpu_req_we    = we;
    cpu_req_addr  = a;
    cpu_req_wdata = d;
    while (!cpu_req_ready) @(negedge clk);
    if (we) begin
      gold[int'(a)] = d;
      exp_q.push_back(d);
    end else begin
      exp_q.push_back(gold_rd(a));
    end
    seen = rsp_cnt;
    lat  = 0;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    forever begin
      #3;
      lat++;
      if (rsp_cnt != seen) break;
      @(negedge clk);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin
    int lat;
    logic [LINE_W-1:0] blk;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #3;
    check("R1 ready after reset", LINE_W'(cpu_req_ready), 1);
    check("R1 no read after reset", LINE_W'(mem_rd_valid), 0);
    check("R1 no write after reset", LINE_W'(mem_wr_valid), 0);

    // cold miss with slow memory: R1, R5, R2
    rd_lat = 2;
    fork
      do_req(1'b0, mk(7'd1, 3'd0, 2'd1), '0, lat);
      begin
        repeat (3) @(negedge clk);
        #4;
        check("R2 ready low while miss pending", LINE_W'(cpu_req_ready), 0);
        check("R5 read held while memory slow", LINE_W'(mem_rd_valid), 1);
        check("R5 read block address", LINE_W'(mem_rd_addr), LINE_W'({7'd1, 3'd0}));
      end
    join
    check("R5 clean miss latency", LINE_W'(lat), 4);
    check("R1 cold access read once", LINE_W'(rd_fires), 1);
    check("R5 no write on clean miss", LINE_W'(wr_fires), 0);
    rd_lat = 0;

    // read hit on another word: R3, R12
    do_req(1'b0, mk(7'd1, 3'd0, 2'd3), '0, lat);
    check("R3 read hit latency", LINE_W'(lat), 1);
    check("R3 hit has no read", LINE_W'(rd_fires), 1);

    // write hit and read back: R4
    do_req(1'b1, mk(7'd1, 3'd0, 2'd2), 32'hAAAA_0001, lat);
    check("R4 write hit latency", LINE_W'(lat), 1);
    do_req(1'b0, mk(7'd1, 3'd0, 2'd2), '0, lat);
    check("R4 write hit no traffic", LINE_W'(rd_fires + wr_fires), 1);

    // dirty eviction with write held off: R6
    wr_block = 1'b1;
    do_req(1'b0, mk(7'd2, 3'd0, 2'd0), '0, lat);
    check("R6 dirty miss latency", LINE_W'(lat), 2);
    check("R6 read issued", LINE_W'(rd_fires), 2);
    check("R6 write not before read", LINE_W'(wr_fires), 0);
    @(negedge clk);
    #3;
    check("R6 buffered write requested", LINE_W'(mem_wr_valid), 1);
    check("R6 buffered write address", LINE_W'(mem_wr_addr), LINE_W'({7'd1, 3'd0}));

    // hit while the buffer is stuck: R7
    do_req(1'b0, mk(7'd2, 3'd0, 2'd0), '0, lat);
    check("R7 hit latency during drain", LINE_W'(lat), 1);
    check("R7 write still pending", LINE_W'(mem_wr_valid), 1);

    // reclaim the buffered block: R9
    do_req(1'b0, mk(7'd1, 3'd0, 2'd2), '0, lat);
    check("R9 reclaim latency", LINE_W'(lat), 1);
    check("R9 reclaim has no read", LINE_W'(rd_fires), 2);
    @(negedge clk);
    #3;
    check("R9 buffer empty after clean victim", LINE_W'(mem_wr_valid), 0);
    do_req(1'b0, mk(7'd1, 3'd0, 2'd0), '0, lat);
    check("R9 reclaimed block hits", LINE_W'(lat), 1);

    // write miss allocate: R10
    do_req(1'b1, mk(7'd3, 3'd1, 2'd0), 32'hBBBB_0002, lat);
    check("R10 write miss latency", LINE_W'(lat), 2);
    check("R10 write miss fetched block", LINE_W'(rd_fires), 3);
    do_req(1'b0, mk(7'd3, 3'd1, 2'd0), '0, lat);
    check("R10 allocated line hits", LINE_W'(lat), 1);

    // reclaimed block is dirty: evicting it fills the buffer again
    do_req(1'b0, mk(7'd4, 3'd0, 2'd0), '0, lat);
    check("R9 reclaimed block evicted as dirty", LINE_W'(wr_fires), 0);
    check("R6 second dirty miss latency", LINE_W'(lat), 2);

    // miss with a full buffer waits for the drain: R8
    fork
      do_req(1'b0, mk(7'd5, 3'd1, 2'd0), '0, lat);
      begin
        repeat (6) @(negedge clk);
        #4;
        check("R8 no read while buffer full", LINE_W'(rd_fires), 4);
        check("R8 requester still stalled", LINE_W'(cpu_req_ready), 0);
        wr_block = 1'b0;
      end
    join
    check("R8 buffered write accepted", LINE_W'(wr_fires), 1);
    check("R8 read after drain", LINE_W'(rd_fires), 5);
    check("R8 write precedes read", LINE_W'(wr_fire_cyc < rd_fire_cyc), 1);

    // buffer drains the second victim; memory contents
    repeat (4) @(negedge clk);
    #3;
    check("R4 second victim drained", LINE_W'(wr_fires), 2);
    blk = blk_read(int'({7'd3, 3'd1}));
    check("R10 written word reached memory", LINE_W'(blk[31:0]), LINE_W'(32'hBBBB_0002));
    blk = blk_read(int'({7'd1, 3'd0}));
    check("R4 written word reached memory", LINE_W'(blk[95:64]), LINE_W'(32'hAAAA_0001));

    // refetch from memory after write-back
    do_req(1'b0, mk(7'd1, 3'd0, 2'd2), '0, lat);
    check("R5 refetch latency", LINE_W'(lat), 2);

    check("R11 channel never shared", LINE_W'(both_cnt), 0);
    check("R2 all responses consumed", LINE_W'(exp_q.size()), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule